// File: doc/BRIEF.md
# Tree Partial-Sum Reduction Engine

This block collapses a bank of signed partial sums, one per lane, into a single total. A start pulse captures every lane value in parallel. The engine then runs a series of rounds, one per clock cycle. In each round the number of live lanes is halved, and each surviving lower lane takes in the value of its partner in the upper half. When the live count is odd, the element left without a partner is folded into lane 0 in the same round. Because of this fold, the lane count does not have to be a power of two.

The register update is the barrier between rounds: every lane reads the values from the previous round before any lane writes a new one. When a round leaves a single live lane, the engine returns to idle. It raises a one-cycle done pulse and presents the total on a result register. That register holds its value until the next accepted run completes. The lane count and data width are parameters, and all additions wrap modulo 2^width.

Top module: `tree_sum_reducer`

## Requirements
- R1: After reset, busy and done are low and result is zero.
- R2: A start pulse while idle captures all lanes from the flattened input, where lane k occupies bits [k*DATA_W +: DATA_W], and busy is high in the following cycle.
- R3: One round completes per clock cycle. With N lanes, done is high in the cycle that begins floor(log2 N) clock edges after the edge that captured the inputs.
- R4: When done is high, result equals the sum of all N captured lane values.
- R5: The value of every lane reaches the total whatever its position, including an element left without a partner by an odd live count (for N=10 the live count goes 10, 5, 2, 1, and lane 4 is folded into lane 0 at the 5-to-2 step).
- R6: done is high for exactly one cycle per run, and busy is low in that cycle and afterwards until the next start.
- R7: result changes only in a cycle in which done is high, and holds steady while the engine is idle.
- R8: A start pulse while busy is ignored: the running sum, the timing of done and the return to idle are unaffected, and no second run follows.
- R9: Additions wrap modulo 2^DATA_W. With ten lanes all holding -1 at DATA_W=8, the result is 8'hF6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a reduction with the values on laneIn (taken only when idle) |
| laneIn | input | NUM_LANES*DATA_W | Packed lane values, lane k at bits [k*DATA_W +: DATA_W] |
| busy | output | 1 | A reduction is in progress |
| done | output | 1 | One-cycle pulse when the total is ready |
| result | output | DATA_W | Total of the last completed run, held until the next completes |

## Verification
The assertions rely on one assumption: start is a clean synchronous level. They do not require start to be kept low during a run, because the engine must ignore it then. The round-count check takes the capture edge to be the cycle in which start is seen while idle. The bench therefore presents start for exactly one cycle at a time from an idle state, and it deliberately raises start once more in the middle of a run to exercise R8. The bench drives lane data only at falling edges and keeps it in place through the capture edge.

// File: rtl/redtree_pkg.sv
package redtree_pkg;

  // Live-lane counts up to 16 fit in five bits.
  localparam int CNT_W = 5;

  typedef struct packed {
    logic             load;    // capture all lanes
    logic             step;    // perform one reduction round
    logic             fold;    // live count is odd: lane 0 takes the stranded element
    logic             finish;  // this round leaves a single live lane
    logic [CNT_W-1:0] half;    // live count after this round
  } redCtl_t;

endpackage

// File: rtl/redtree_ctrl.sv
module redtree_ctrl
  import redtree_pkg::*;
#(
  parameter int NUM_LANES = 10
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output redCtl_t ctl,
  output logic    busy,
  output logic    done
);

  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(NUM_LANES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] liveCnt;
  logic [CNT_W-1:0] nextHalf;
  logic             accept;
  logic             lastRound;

  assign accept    = start && !busy;
  assign nextHalf  = liveCnt >> 1;
  assign lastRound = busy && (nextHalf == CNT_ONE);

  always_comb begin
    ctl.load   = accept;
    ctl.step   = busy;
    ctl.fold   = busy && liveCnt[0];
    ctl.finish = lastRound;
    ctl.half   = nextHalf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      liveCnt <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        liveCnt <= CNT_INIT;
      end else if (busy) begin
        liveCnt <= nextHalf;
        if (lastRound) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/redtree_dp.sv
module redtree_dp
  import redtree_pkg::*;
#(
  parameter int NUM_LANES = 10,
  parameter int DATA_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  redCtl_t                     ctl,
  input  logic [NUM_LANES*DATA_W-1:0] laneIn,
  output logic [DATA_W-1:0]           result
);

  logic [DATA_W-1:0] laneQ [NUM_LANES];
  logic [DATA_W-1:0] laneD [NUM_LANES];
  logic [DATA_W-1:0] resQ;

  // Next value of each lane for one round. Every term is read from
  // laneQ, so all lanes see the previous round's state (the barrier).
  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [DATA_W-1:0] partner;
    logic [DATA_W-1:0] stray;

    always_comb begin
      partner = '0;
      for (int j = 0; j < NUM_LANES; j++) begin
        if ((g < int'(ctl.half)) && (j == g + int'(ctl.half))) begin
          partner = laneQ[j];
        end
      end
    end

    if (g == 0) begin : gFold
      always_comb begin
        stray = '0;
        for (int j = 0; j < NUM_LANES; j++) begin
          if (ctl.fold && (j == 2 * int'(ctl.half))) begin
            stray = laneQ[j];
          end
        end
      end
    end else begin : gNoFold
      assign stray = '0;
    end

    assign laneD[g] = laneQ[g] + partner + stray;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneQ[g] <= '0;
      end else if (ctl.load) begin
        laneQ[g] <= laneIn[g*DATA_W +: DATA_W];
      end else if (ctl.step) begin
        laneQ[g] <= laneD[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ <= '0;
    end else if (ctl.finish) begin
      resQ <= laneD[0];
    end
  end

  assign result = resQ;

endmodule

// File: rtl/tree_sum_reducer.sv
module tree_sum_reducer
  import redtree_pkg::*;
#(
  parameter int NUM_LANES = 10,
  parameter int DATA_W    = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [NUM_LANES*DATA_W-1:0] laneIn,
  output logic                        busy,
  output logic                        done,
  output logic [DATA_W-1:0]           result
);

  redCtl_t ctl;

  redtree_ctrl #(.NUM_LANES(NUM_LANES)) ctrl_i (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctl  (ctl),
    .busy (busy),
    .done (done)
  );

  redtree_dp #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .laneIn(laneIn),
    .result(result)
  );

endmodule

// File: rtl/redtree_chk.sv
module redtree_chk #(
  parameter int NUM_LANES = 10,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result
);

  localparam int ROUNDS = $clog2(NUM_LANES + 1) - 1;

  logic [7:0] roundCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      roundCnt <= '0;
    end else if (start && !busy) begin
      roundCnt <= '0;
    end else if (busy && roundCnt != 8'hFF) begin
      roundCnt <= roundCnt + 8'd1;
    end
  end

  // R2
  start_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3
  round_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (roundCnt == 8'(ROUNDS)));

  // R3
  round_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    roundCnt <= 8'(ROUNDS));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  // R8
  busy_runs_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

endmodule

bind tree_sum_reducer redtree_chk #(.NUM_LANES(NUM_LANES), .DATA_W(DATA_W)) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .busy  (busy),
  .done  (done),
  .result(result)
);

// File: tb/tree_sum_reducer_tb_top.sv
module tree_sum_reducer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 10;
  localparam int W          = 8;
  localparam int ROUNDS     = 3;   // floor(log2 10)
  localparam int WATCHDOG   = 20000;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N*W-1:0] laneIn = '0;
  logic           busy;
  logic           done;
  logic [W-1:0]   result;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tree_sum_reducer #(.NUM_LANES(N), .DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .laneIn(laneIn),
    .busy(busy), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] sumOf(input logic [N*W-1:0] v);
    logic [W-1:0] s = '0;
    for (int k = 0; k < N; k++) s = s + v[k*W +: W];
    return s;
  endfunction

  // One complete run; poke raises start again in the middle of it.
  task automatic runVec(input logic [N*W-1:0] v, input bit poke, input string req);
    logic [W-1:0] exp;
    int k;
    exp = sumOf(v);
    @(negedge clk);
    laneIn = v;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", int'(busy), 1);
    k = 1;
    while (!done && k < 40) begin
      @(negedge clk);
      k++;
      if (poke && k == 2) begin
        laneIn = ~v;
        start  = 1'b1;
      end
      if (poke && k == 3) start = 1'b0;
    end
    // done appears ROUNDS edges after the capture edge
    check(k == ROUNDS + 1, "R3", k - 1, ROUNDS);
    check(result == exp, req, int'(result), int'(exp));
    check(busy == 1'b0, "R6", int'(busy), 0);
    laneIn = ~v;
    @(negedge clk);
    check(done == 1'b0, "R6", int'(done), 0);
    check(result == exp, "R7", int'(result), int'(exp));
    if (poke) begin
      check(busy == 1'b0, "R8", int'(busy), 0);
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R8", int'(busy), 0);
    end
  endtask

  initial begin
    logic [N*W-1:0] v;
    logic [31:0] seed;
    repeat (3) @(negedge clk);
    // R1
    check(busy == 1'b0, "R1", int'(busy), 0);
    check(done == 1'b0, "R1", int'(done), 0);
    check(result == '0, "R1", int'(result), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R5: each lane alone must reach the total
    for (int lane = 0; lane < N; lane++) begin
      v = '0;
      v[lane*W +: W] = W'(3 * lane + 7);
      runVec(v, 1'b0, "R5");
    end

    // R4: ramp and alternating signs
    for (int k = 0; k < N; k++) v[k*W +: W] = W'(k + 1);
    runVec(v, 1'b0, "R4");
    for (int k = 0; k < N; k++) v[k*W +: W] = (k % 2 == 0) ? W'(100) : W'(-37);
    runVec(v, 1'b0, "R4");

    // R9: all -1 gives 8'hF6
    v = '1;
    runVec(v, 1'b0, "R9");
    for (int k = 0; k < N; k++) v[k*W +: W] = W'(127);
    runVec(v, 1'b0, "R9");

    // R7: result holds while idle with inputs changing
    for (int k = 0; k < 4; k++) begin
      laneIn = {N{W'(k * 13)}};
      @(negedge clk);
      check(result == W'(N * 127), "R7", int'(result), int'(W'(N * 127)));
    end

    // R8: start while busy ignored
    for (int k = 0; k < N; k++) v[k*W +: W] = W'(5 * k + 2);
    runVec(v, 1'b1, "R8");

    // R4: pseudo-random sweep
    seed = 32'h1234_5678;
    for (int t = 0; t < 40; t++) begin
      for (int k = 0; k < N; k++) begin
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v[k*W +: W] = seed[W-1:0];
      end
      runVec(v, (t % 8) == 3, "R4");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule